// File: doc/BRIEF.md
# Lockable Pad Attribute Register File

This block keeps one attribute word for every multiplexed pad and every dedicated pad of a chip. It presents all of these words at once, as two packed arrays, to the pad ring. Software reaches the words through a simple synchronous register port that has an address, a write strobe, write data and combinational read data.

Each pad comes with a constant mask that marks which attribute bits its pad cell supports. A write stores only the legal part of the data. Software can therefore find out what a pad supports by writing a value and reading it back. Bit 0 selects inversion and bit 1 selects open drain. These two bits can always be written.

A one-bit lock-enable register sits at the start of the address map. Clearing it freezes every attribute word until the next reset.

Top module: `padattr_regfile`

## Requirements
- R1: After reset the lock-enable bit is 1 (open) and every attribute word is zero.
- R2: Address 0 holds the lock-enable bit. Addresses 1 to NUM_MUX hold the multiplexed pad words in pad order. The next NUM_DED addresses hold the dedicated pad words in pad order.
- R3: Attribute bits 0 (inversion) and 1 (open drain) store the written value on every pad, whatever that pad's mask says.
- R4: An attribute bit at position 2 or above stores the written value only where the pad's legal mask has a 1. Elsewhere it reads back as 0.
- R5: Pad word i appears on bits [i*ATTR_W +: ATTR_W] of its output array, from the clock edge of the write onwards.
- R6: Writing data with bit 0 equal to 0 to address 0 clears the lock-enable bit. After that, writes to attribute addresses change no word. Address 0 reads back with bit 0 equal to the lock-enable bit and all other bits 0.
- R7: Writing data with bit 0 equal to 1 to address 0 leaves the lock-enable bit unchanged. Once the bit is cleared, only a reset sets it again.
- R8: A read of an address above NUM_MUX+NUM_DED returns zero. A write to such an address changes no register.
- R9: Read data follows the address in the same cycle and shows the value stored before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | ATTR_W | Write data |
| reg_rdata_o | output | ATTR_W | Read data for reg_addr_i |
| mux_legal_i | input | NUM_MUX*ATTR_W | Constant legal-bit masks, multiplexed pads |
| ded_legal_i | input | NUM_DED*ATTR_W | Constant legal-bit masks, dedicated pads |
| mux_attr_o | output | NUM_MUX*ATTR_W | Attribute words, multiplexed pads |
| ded_attr_o | output | NUM_DED*ATTR_W | Attribute words, dedicated pads |

## Verification
The bench builds the block with 3 multiplexed pads, 5 dedicated pads, a 12-bit attribute word and a 4-bit address. The 12-bit word exercises the masking of optional bits above bit 9. The 4-bit address leaves addresses 9 to 15 unmapped, so the bench can write to them and read from them. The masks mix an all-ones pad, an all-zeros pad and random pads. This shows both the forced bits 0 and 1 and the filtering of every optional bit. A second reset after the lock shows that only reset reopens the block.

// File: rtl/padattr_regfile.sv
`timescale 1ns/1ps
module padattr_regfile #(
  parameter int NUM_MUX = 4,
  parameter int NUM_DED = 16,
  parameter int ATTR_W  = 10,
  parameter int ADDR_W  = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [ADDR_W-1:0]                 reg_addr_i,
  input  logic                              reg_we_i,
  input  logic [ATTR_W-1:0]                 reg_wdata_i,
  output logic [ATTR_W-1:0]                 reg_rdata_o,
  input  logic [NUM_MUX-1:0][ATTR_W-1:0]    mux_legal_i,
  input  logic [NUM_DED-1:0][ATTR_W-1:0]    ded_legal_i,
  output logic [NUM_MUX-1:0][ATTR_W-1:0]    mux_attr_o,
  output logic [NUM_DED-1:0][ATTR_W-1:0]    ded_attr_o
);
  localparam int MUX_BASE = 1;
  localparam int DED_BASE = MUX_BASE + NUM_MUX;
  localparam logic [ATTR_W-1:0] ALWAYS_RW = ATTR_W'(3);

  logic unlock_q;
  logic [NUM_MUX-1:0][ATTR_W-1:0] mux_q;
  logic [NUM_DED-1:0][ATTR_W-1:0] ded_q;

  wire lock_hit = (reg_addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b1;
      mux_q    <= '0;
      ded_q    <= '0;
    end else if (reg_we_i) begin
      if (lock_hit && !reg_wdata_i[0]) unlock_q <= 1'b0;
      if (unlock_q) begin
        for (int i = 0; i < NUM_MUX; i++)
          if (reg_addr_i == ADDR_W'(MUX_BASE + i))
            mux_q[i] <= reg_wdata_i & (mux_legal_i[i] | ALWAYS_RW);
        for (int j = 0; j < NUM_DED; j++)
          if (reg_addr_i == ADDR_W'(DED_BASE + j))
            ded_q[j] <= reg_wdata_i & (ded_legal_i[j] | ALWAYS_RW);
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (lock_hit) reg_rdata_o[0] = unlock_q;
    for (int i = 0; i < NUM_MUX; i++)
      if (reg_addr_i == ADDR_W'(MUX_BASE + i)) reg_rdata_o = mux_q[i];
    for (int j = 0; j < NUM_DED; j++)
      if (reg_addr_i == ADDR_W'(DED_BASE + j)) reg_rdata_o = ded_q[j];
  end

  assign mux_attr_o = mux_q;
  assign ded_attr_o = ded_q;
endmodule

// File: rtl/padattr_regfile_chk.sv
`timescale 1ns/1ps
module padattr_regfile_chk #(
  parameter int NUM_MUX = 4,
  parameter int NUM_DED = 16,
  parameter int ATTR_W  = 10,
  parameter int ADDR_W  = 5
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              reg_addr_i,
  input logic [ATTR_W-1:0]              reg_rdata_o,
  input logic [NUM_MUX-1:0][ATTR_W-1:0] mux_legal_i,
  input logic [NUM_DED-1:0][ATTR_W-1:0] ded_legal_i,
  input logic [NUM_MUX-1:0][ATTR_W-1:0] mux_attr_o,
  input logic [NUM_DED-1:0][ATTR_W-1:0] ded_attr_o,
  input logic                           unlock_q
);
  localparam int LAST = NUM_MUX + NUM_DED;
  localparam logic [ATTR_W-1:0] ALWAYS_RW = ATTR_W'(3);

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> !unlock_q); // R7
  AST_MUX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> $stable(mux_attr_o)); // R6
  AST_DED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlock_q |=> $stable(ded_attr_o)); // R6
  AST_LOCK_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> (reg_rdata_o == ATTR_W'(unlock_q))); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(reg_addr_i) > LAST) |-> (reg_rdata_o == '0)); // R8

  for (genvar g = 0; g < NUM_MUX; g++) begin : g_mux
    AST_MUX_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mux_attr_o[g] & ~(mux_legal_i[g] | ALWAYS_RW)) == '0); // R4
  end
  for (genvar g = 0; g < NUM_DED; g++) begin : g_ded
    AST_DED_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ded_attr_o[g] & ~(ded_legal_i[g] | ALWAYS_RW)) == '0); // R4
  end
endmodule

bind padattr_regfile padattr_regfile_chk #(
  .NUM_MUX(NUM_MUX), .NUM_DED(NUM_DED), .ATTR_W(ATTR_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i),
  .reg_rdata_o(reg_rdata_o), .mux_legal_i(mux_legal_i),
  .ded_legal_i(ded_legal_i), .mux_attr_o(mux_attr_o),
  .ded_attr_o(ded_attr_o), .unlock_q(unlock_q)
);

// File: tb/padattr_regfile_bench.sv
`timescale 1ns/1ps
module padattr_regfile_bench;
  localparam int NM = 3;
  localparam int ND = 5;
  localparam int W  = 12;
  localparam int AW = 4;
  localparam int LAST = NM + ND;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic we = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [NM-1:0][W-1:0] mux_legal;
  logic [ND-1:0][W-1:0] ded_legal;
  logic [NM-1:0][W-1:0] mux_attr;
  logic [ND-1:0][W-1:0] ded_attr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [W-1:0] m_mux [NM];
  logic [W-1:0] m_ded [ND];
  logic m_open;

  always #2.5 clk = ~clk;

  padattr_regfile #(.NUM_MUX(NM), .NUM_DED(ND), .ATTR_W(W), .ADDR_W(AW)) u_padattr_regfile (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mux_legal_i(mux_legal),
    .ded_legal_i(ded_legal), .mux_attr_o(mux_attr), .ded_attr_o(ded_attr)
  );

  function automatic logic [W-1:0] exp_read(int a);
    if (a == 0) return W'(m_open);
    if (a >= 1 && a <= NM) return m_mux[a-1];
    if (a > NM && a <= LAST) return m_ded[a-1-NM];
    return '0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_open = 1'b1;
    for (int i = 0; i < NM; i++) m_mux[i] = '0;
    for (int j = 0; j < ND; j++) m_ded[j] = '0;
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a == 0) begin
      if (!d[0]) m_open = 1'b0;
    end else if (m_open && a <= NM) begin
      m_mux[a-1] = d & (mux_legal[a-1] | W'(3));
    end else if (m_open && a <= LAST) begin
      m_ded[a-1-NM] = d & (ded_legal[a-1-NM] | W'(3));
    end
  endtask

  task automatic rd(string req, int a);
    addr = AW'(a); #1;
    chk(req, 64'(rdata), 64'(exp_read(a)));
  endtask

  task automatic outs(string req);
    logic [63:0] em, ed;
    em = '0; ed = '0;
    for (int i = 0; i < NM; i++) em[i*W +: W] = m_mux[i];
    for (int j = 0; j < ND; j++) ed[j*W +: W] = m_ded[j];
    chk(req, 64'(mux_attr), em);
    chk(req, 64'(ded_attr), ed);
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < (1 << AW); a++) rd(req, a);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      report();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mux_legal[0] = '1;
    ded_legal[0] = '0;
    for (int i = 1; i < NM; i++) mux_legal[i] = W'($urandom);
    for (int j = 1; j < ND; j++) ded_legal[j] = W'($urandom);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values, R2 map, R8 unmapped reads
    read_all("R1");
    outs("R1");

    // R3 and R4 directed masks
    wr(1, '1);        rd("R4", 1);
    wr(NM + 1, '1);   rd("R3", NM + 1);
    chk("R3", 64'(ded_attr[0]), 64'(3));
    wr(NM + 1, W'(2)); rd("R3", NM + 1);
    outs("R5");

    // R8 unmapped write
    wr(LAST + 1, '1); wr((1 << AW) - 1, '1);
    read_all("R8");

    // R9 read shows old value in the write cycle
    @(negedge clk);
    addr = AW'(2); wdata = ~m_mux[1]; we = 1'b1; #1;
    chk("R9", 64'(rdata), 64'(m_mux[1]));
    @(negedge clk); we = 1'b0;
    m_mux[1] = wdata & (mux_legal[1] | W'(3));
    rd("R9", 2);

    // R7 writing 1 to the open lock keeps it open; random traffic
    for (int n = 0; n < 300; n++) begin
      int a;
      logic [W-1:0] d;
      a = int'($urandom_range(0, (1 << AW) - 1));
      d = W'($urandom);
      if (a == 0) d[0] = 1'b1;
      wr(a, d);
      rd((a == 0) ? "R7" : "R4", a);
      outs("R5");
    end
    read_all("R2");

    // R6 lock
    wr(0, W'(2));
    rd("R6", 0);
    for (int n = 0; n < 60; n++) begin
      int a;
      a = int'($urandom_range(1, LAST));
      wr(a, W'($urandom));
      rd("R6", a);
    end
    outs("R6");
    wr(0, '1);
    rd("R7", 0);
    wr(1, W'(1) ^ m_mux[0]);
    rd("R7", 1);
    outs("R7");

    // R1 a second reset reopens
    @(negedge clk); rst_n = 1'b0;
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    read_all("R1");
    wr(2, W'(1)); rd("R1", 2);

    done = 1;
    report();
  end
endmodule